// File: doc/BRIEF.md
# Valid-Invalid Snooping Coherence Controller

This block keeps the coherence state of a small write-through cache that shares a snooping bus with other agents. Each cache frame carries one valid bit and a stored tag. The processor side hands in load and store requests, each with a frame index and a tag. A load that finds its frame valid under the same tag finishes locally. Any other load fetches the line over the bus and marks the frame valid. Every store is written through to the bus, and a store never allocates a frame.

The controller also watches every transaction on the shared bus. A write made by another agent that matches a valid frame in both index and tag clears that frame. Reads by other agents, and transactions tagged with this controller's own agent number, leave the local state alone. The data array, arbitration between caches and the memory itself are outside the block. The bus side is a single request line held until a one-cycle grant.

The processor request port is valid/ready. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no bus transaction is pending, so at most one is ever outstanding. A requester that sees `req_ready` low must keep its request fields steady until it is taken. Each request produces exactly one `rsp_done` pulse.

Top module: `vi_snoop_ctrl`

## Requirements
- R1: After reset every frame is Invalid, `req_ready` is 1, and `bus_req` and `rsp_done` are 0. A first load to any frame, with any tag, is therefore a miss.
- R2: A load that misses raises `bus_req` with `bus_wr`=0 and `bus_addr`={tag, index} in the cycle after acceptance. On the edge where `bus_gnt` is seen, the frame becomes Valid under that tag. `rsp_done`=1 and `rsp_hit`=0 appear in the following cycle.
- R3: A load to a Valid frame with a matching tag raises `rsp_done`=1 and `rsp_hit`=1 in the cycle after acceptance, and `bus_req` stays 0.
- R4: A store to a Valid frame with a matching tag issues a bus write (`bus_wr`=1, `bus_addr`={tag, index}), and the frame stays Valid.
- R5: A store that misses issues a bus write and does not allocate. A later load to the same index and tag is still a miss.
- R6: A snoop with `snp_valid`=1 and `snp_write`=1, from a source other than `OWN_ID`, whose `snp_addr` ({tag, index}) matches a Valid frame, makes that frame Invalid. A tag mismatch has no effect.
- R7: A snooped read (`snp_write`=0) from another agent leaves every frame unchanged.
- R8: A snooped transaction whose `snp_src` equals `OWN_ID` is ignored, so the controller's own write never invalidates its own frame.
- R9: Only one bus transaction is outstanding at a time. `req_ready` stays 0 from acceptance until the cycle after the grant, and `bus_req`, `bus_wr` and `bus_addr` hold steady until `bus_gnt` is seen.
- R10: A load to a frame that is Valid under a different tag is a miss. Its fill replaces the stored tag, so the old tag then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_idx | input | IDX_W | Frame index |
| req_tag | input | TAG_W | Address tag |
| rsp_done | output | 1 | One-cycle pulse: request finished |
| rsp_hit | output | 1 | With rsp_done: load served locally |
| bus_req | output | 1 | Bus transaction requested |
| bus_gnt | input | 1 | Grant; the transaction completes on this edge |
| bus_wr | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | TAG_W+IDX_W | {tag, index} of the transaction |
| snp_valid | input | 1 | A bus transaction is observed this cycle |
| snp_write | input | 1 | The observed transaction is a write |
| snp_src | input | SRC_W | Agent number of the observed transaction's issuer |
| snp_addr | input | TAG_W+IDX_W | {tag, index} of the observed transaction |

## Verification
The assertions assume that the bus never grants while `bus_req` is low. They also assume that a foreign snoop write never falls in the cycle where this controller's own grant completes, because a shared bus carries one transaction per cycle. The stimulus keeps to both rules: grants are raised only while a request is pending, and snoops are driven only while the controller is idle. A snoop in the same cycle as a load's acceptance is treated as ordered after that load. The stimulus avoids that overlap, so the outcome of each snoop can be read cleanly through a later load.

// File: rtl/vi_snoop_pkg.sv
package vi_snoop_pkg;
  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_BUS  = 1'b1
  } ctl_state_e;

  typedef enum logic {
    BUS_READ  = 1'b0,
    BUS_WRITE = 1'b1
  } bus_kind_e;
endpackage

// File: rtl/vi_frame_store.sv
module vi_frame_store #(
  parameter int FRAMES = 16,
  parameter int TAG_W  = 8,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic [IDX_W-1:0] sn_idx,
  input  logic [TAG_W-1:0] sn_tag,
  output logic             sn_hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx
);
  logic [FRAMES-1:0] valid_q;
  logic [FRAMES-1:0] valid_d;
  logic [FRAMES-1:0] load_tag;
  logic [TAG_W-1:0]  tag_q [FRAMES];

  // Per-frame next state: a fill wins over an invalidate to the same frame.
  for (genvar g = 0; g < FRAMES; g++) begin : g_frame
    logic fill_here;
    logic inv_here;
    assign fill_here   = fill_en && (fill_idx == IDX_W'(g));
    assign inv_here    = inv_en && (inv_idx == IDX_W'(g));
    assign load_tag[g] = fill_here;
    assign valid_d[g]  = fill_here ? 1'b1 : (inv_here ? 1'b0 : valid_q[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < FRAMES; i++) tag_q[i] <= '0;
    end else begin
      valid_q <= valid_d;
      for (int i = 0; i < FRAMES; i++)
        if (load_tag[i]) tag_q[i] <= fill_tag;
    end
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign sn_hit = valid_q[sn_idx] && (tag_q[sn_idx] == sn_tag);

  // R2: a fill leaves the frame valid and holding the new tag
  a_r2_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(fill_idx)] && (tag_q[$past(fill_idx)] == $past(fill_tag)));

  // R6: an invalidate not overlapped by a fill clears the frame
  a_r6_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !(fill_en && fill_idx == inv_idx)) |=> !valid_q[$past(inv_idx)]);
endmodule

// File: rtl/vi_snoop_filter.sv
module vi_snoop_filter #(
  parameter int TAG_W  = 8,
  parameter int IDX_W  = 4,
  parameter int SRC_W  = 2,
  parameter int OWN_ID = 1,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [SRC_W-1:0]  snp_src,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [IDX_W-1:0]  sn_idx,
  output logic [TAG_W-1:0]  sn_tag,
  input  logic              sn_hit,
  output logic              inv_en,
  output logic [IDX_W-1:0]  inv_idx
);
  logic foreign;

  assign sn_idx  = snp_addr[IDX_W-1:0];
  assign sn_tag  = snp_addr[ADDR_W-1:IDX_W];
  assign foreign = (snp_src != SRC_W'(OWN_ID));
  // Only a foreign write that hits a valid frame kills it; reads are harmless.
  assign inv_en  = snp_valid && snp_write && foreign && sn_hit;
  assign inv_idx = sn_idx;
endmodule

// File: rtl/vi_req_ctl.sv
module vi_req_ctl
  import vi_snoop_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int IDX_W = 4,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [TAG_W-1:0]  req_tag,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              lk_hit,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              fill_en,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              rsp_done,
  output logic              rsp_hit
);
  ctl_state_e       state_q;
  bus_kind_e        kind_q;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  logic             done_q;
  logic             hit_q;
  logic             accept;
  logic             local_hit;

  assign req_ready = (state_q == CTL_IDLE);
  assign accept    = req_valid && req_ready;
  assign lk_idx    = req_idx;
  assign lk_tag    = req_tag;
  assign local_hit = !req_store && lk_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CTL_IDLE;
      kind_q  <= BUS_READ;
      idx_q   <= '0;
      tag_q   <= '0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      unique case (state_q)
        CTL_IDLE: if (accept) begin
          if (local_hit) begin
            done_q <= 1'b1;
            hit_q  <= 1'b1;
          end else begin
            state_q <= CTL_BUS;
            kind_q  <= req_store ? BUS_WRITE : BUS_READ;
            idx_q   <= req_idx;
            tag_q   <= req_tag;
          end
        end
        CTL_BUS: if (bus_gnt) begin
          state_q <= CTL_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= CTL_IDLE;
      endcase
    end
  end

  assign bus_req  = (state_q == CTL_BUS);
  assign bus_wr   = (kind_q == BUS_WRITE);
  assign bus_addr = {tag_q, idx_q};
  // Stores never allocate: only a granted read fills the frame.
  assign fill_en  = bus_req && bus_gnt && (kind_q == BUS_READ);
  assign fill_idx = idx_q;
  assign fill_tag = tag_q;
  assign rsp_done = done_q;
  assign rsp_hit  = hit_q;

  // R9: no new request is taken while a bus transaction is pending
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !req_ready);

  // R9: an ungranted request holds its command and address
  a_r9_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req && $stable(bus_addr) && $stable(bus_wr));

  // R3: a local load hit finishes next cycle without using the bus
  a_r3_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_store && lk_hit) |=> rsp_done && rsp_hit && !bus_req);

  // R2: a granted transaction always reports completion next cycle
  a_r2_done_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> rsp_done && !rsp_hit && req_ready);
endmodule

// File: rtl/vi_snoop_ctrl.sv
module vi_snoop_ctrl #(
  parameter int FRAMES = 16,
  parameter int TAG_W  = 8,
  parameter int SRC_W  = 2,
  parameter int OWN_ID = 1,
  localparam int IDX_W  = $clog2(FRAMES),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_done,
  output logic              rsp_hit,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [SRC_W-1:0]  snp_src,
  input  logic [ADDR_W-1:0] snp_addr
);
  logic [IDX_W-1:0] lk_idx, sn_idx, fill_idx, inv_idx;
  logic [TAG_W-1:0] lk_tag, sn_tag, fill_tag;
  logic             lk_hit, sn_hit, fill_en, inv_en;

  vi_req_ctl #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_idx(req_idx), .req_tag(req_tag),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .rsp_done(rsp_done), .rsp_hit(rsp_hit)
  );

  vi_snoop_filter #(.TAG_W(TAG_W), .IDX_W(IDX_W), .SRC_W(SRC_W), .OWN_ID(OWN_ID)) u_snp (
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_src(snp_src), .snp_addr(snp_addr),
    .sn_idx(sn_idx), .sn_tag(sn_tag), .sn_hit(sn_hit),
    .inv_en(inv_en), .inv_idx(inv_idx)
  );

  vi_frame_store #(.FRAMES(FRAMES), .TAG_W(TAG_W)) u_frames (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .sn_idx(sn_idx), .sn_tag(sn_tag), .sn_hit(sn_hit),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .inv_en(inv_en), .inv_idx(inv_idx)
  );
endmodule

// File: tb/vi_snoop_ctrl_bench.sv
module vi_snoop_ctrl_bench;
  localparam int FRAMES = 16;
  localparam int TAG_W  = 8;
  localparam int SRC_W  = 2;
  localparam int OWN_ID = 1;
  localparam int IDX_W  = 4;
  localparam int ADDR_W = TAG_W + IDX_W;
  localparam int NVEC   = 16;

  // Vector: [16:15] kind (0 load,1 store,2 snoop read,3 snoop write),
  // [14] own source, [13:10] index, [9:2] tag, [1:0] expect (0 hit,1 bus read,2 bus write,3 none)
  localparam logic [16:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 4'd3, 8'hA5, 2'd1},  // R2 first load misses
    {2'd0, 1'b0, 4'd3, 8'hA5, 2'd0},  // R3 now hits
    {2'd1, 1'b0, 4'd3, 8'hA5, 2'd2},  // R4 store to valid frame
    {2'd0, 1'b0, 4'd3, 8'hA5, 2'd0},  // R4 frame still valid
    {2'd1, 1'b0, 4'd7, 8'h11, 2'd2},  // R5 store miss writes through
    {2'd0, 1'b0, 4'd7, 8'h11, 2'd1},  // R5 not allocated: load misses
    {2'd2, 1'b0, 4'd7, 8'h11, 2'd3},  // R7 foreign read
    {2'd0, 1'b0, 4'd7, 8'h11, 2'd0},  // R7 still hits
    {2'd3, 1'b0, 4'd7, 8'h11, 2'd3},  // R6 foreign write
    {2'd0, 1'b0, 4'd7, 8'h11, 2'd1},  // R6 invalidated: miss
    {2'd3, 1'b1, 4'd7, 8'h11, 2'd3},  // R8 own write observed
    {2'd0, 1'b0, 4'd7, 8'h11, 2'd0},  // R8 still hits
    {2'd3, 1'b0, 4'd7, 8'h22, 2'd3},  // R6 foreign write, other tag
    {2'd0, 1'b0, 4'd7, 8'h11, 2'd0},  // R6 mismatch left frame valid
    {2'd0, 1'b0, 4'd7, 8'h22, 2'd1},  // R10 other tag misses
    {2'd0, 1'b0, 4'd7, 8'h11, 2'd1}   // R10 old tag replaced
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_store = 1'b0;
  logic [IDX_W-1:0]  req_idx = '0;
  logic [TAG_W-1:0]  req_tag = '0;
  logic              req_ready, rsp_done, rsp_hit, bus_req, bus_wr;
  logic              bus_gnt = 1'b0;
  logic [ADDR_W-1:0] bus_addr;
  logic              snp_valid = 1'b0, snp_write = 1'b0;
  logic [SRC_W-1:0]  snp_src = '0;
  logic [ADDR_W-1:0] snp_addr = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vi_snoop_ctrl #(.FRAMES(FRAMES), .TAG_W(TAG_W), .SRC_W(SRC_W), .OWN_ID(OWN_ID)) u_vi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_idx(req_idx), .req_tag(req_tag),
    .rsp_done(rsp_done), .rsp_hit(rsp_hit),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_src(snp_src), .snp_addr(snp_addr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue a load or store and follow it to completion. exp: 0 local hit, 1 bus read, 2 bus write.
  task automatic cpu_op(input bit store, input logic [IDX_W-1:0] idx, input logic [TAG_W-1:0] tag,
                        input int exp, input string req);
    @(negedge clk);
    check(req_ready == 1'b1, {req, " ready before issue"}, 32'(req_ready), 1);
    req_valid = 1'b1; req_store = store; req_idx = idx; req_tag = tag;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp == 0) begin
      check(rsp_done && rsp_hit && !bus_req, {req, " local hit"},
            {29'd0, rsp_done, rsp_hit, bus_req}, 32'b110);
    end else begin
      check(bus_req && (bus_wr == (exp == 2)) && bus_addr == {tag, idx}, {req, " bus request"},
            {bus_req, bus_wr, 18'd0, bus_addr}, {1'b1, exp == 2, 18'd0, tag, idx});
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        check(bus_req && !req_ready && bus_addr == {tag, idx} && !rsp_done, "R9 held while ungranted",
              {bus_req, req_ready, rsp_done, 17'd0, bus_addr}, {3'b100, 17'd0, tag, idx});
      end
      bus_gnt = 1'b1;
      @(negedge clk);
      bus_gnt = 1'b0;
      check(rsp_done && !rsp_hit && !bus_req && req_ready, {req, " done after grant"},
            {28'd0, rsp_done, rsp_hit, bus_req, req_ready}, 32'b1001);
    end
    @(negedge clk);
    check(!rsp_done, {req, " done is one pulse"}, 32'(rsp_done), 0);
  endtask

  task automatic snoop(input bit wr, input bit own, input logic [IDX_W-1:0] idx, input logic [TAG_W-1:0] tag);
    @(negedge clk);
    snp_valid = 1'b1; snp_write = wr;
    snp_src = own ? SRC_W'(OWN_ID) : SRC_W'(OWN_ID + 1);
    snp_addr = {tag, idx};
    @(negedge clk);
    snp_valid = 1'b0;
    check(!bus_req && !rsp_done, "R7 snoop causes no local activity", {30'd0, bus_req, rsp_done}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check(req_ready && !bus_req && !rsp_done, "R1 reset outputs",
          {29'd0, req_ready, bus_req, rsp_done}, 32'b100);
    cpu_op(1'b0, 4'd0, 8'h00, 1, "R1 frame 0 starts invalid");
    cpu_op(1'b0, 4'd15, 8'hFF, 1, "R1 last frame starts invalid");
    cpu_op(1'b0, 4'd15, 8'hFF, 0, "R3 last frame hit");

    for (int i = 0; i < NVEC; i++) begin
      logic [16:0] v;
      v = VEC[i];
      if (v[16:15] < 2)
        cpu_op(v[15], v[13:10], v[9:2], int'(v[1:0]), $sformatf("R-vec%0d", i));
      else
        snoop(v[15], v[14], v[13:10], v[9:2]);
    end

    // R6: foreign write to frame 3 leaves frame 15 alone but kills frame 3
    snoop(1'b1, 1'b0, 4'd3, 8'hA5);
    cpu_op(1'b0, 4'd15, 8'hFF, 0, "R6 other frame untouched");
    cpu_op(1'b0, 4'd3, 8'hA5, 1, "R6 frame 3 invalidated");
    // R8: own store then own write observed keeps frame valid
    cpu_op(1'b1, 4'd3, 8'hA5, 2, "R8 own store");
    snoop(1'b1, 1'b1, 4'd3, 8'hA5);
    cpu_op(1'b0, 4'd3, 8'hA5, 0, "R8 own write ignored");

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule